// File: doc/BRIEF.md
# Logical Destination Matcher

This block decides whether one local interrupt controller takes a fixed-delivery interrupt message seen on the shared message path. It holds three software-written registers: an 8-bit physical identifier, an 8-bit logical identifier, and a format selector that picks flat or cluster logical addressing. Each incoming message brings a destination mode (physical or logical), an 8-bit destination, a 2-bit shorthand and a flag saying whether this controller is the sender. One clock later the block reports whether the message is accepted.

Matching has no sequencing of its own, so the design is a register file, two parallel match paths (physical and logical) and one result register. The shorthand picks the decision: with no shorthand the destination mode picks a match path; the other three codes bypass the destination field. Several controllers may hold the same physical identifier, and each one of them accepts a message addressed to it, because every controller decides on its own registers alone.

Top module: `ldm_top`

## Requirements
- R1: After reset `acc_valid` and `acc_hit` are 0; `acc_valid` equals `msg_valid` one cycle later, and `acc_hit` is never 1 while `acc_valid` is 0.
- R2: With shorthand 2'b00 and `msg_logical`=0, the message is accepted exactly when `msg_dest` equals the physical identifier; two controllers holding the same identifier both accept it. The identifier resets to parameter `RESET_ID` (default 8'h01) and is written from `cfg_wdata[31:24]` when `cfg_sel`=2'b00.
- R3: With shorthand 2'b00 and `msg_logical`=0, destination 8'hFF is accepted by every controller.
- R4: In flat format with shorthand 2'b00 and `msg_logical`=1, the message is accepted exactly when `msg_dest` AND the logical identifier is nonzero. The logical identifier resets to 0 and is written from `cfg_wdata[31:24]` when `cfg_sel`=2'b01.
- R5: In cluster format with shorthand 2'b00 and `msg_logical`=1, the message is accepted when the upper 4 destination bits equal the upper 4 logical identifier bits and the lower 4 bits of both overlap; destination 8'hFF is accepted regardless.
- R6: The format register is written when `cfg_sel`=2'b10; `cfg_wdata[31:28]`=4'hF selects flat, any other value selects cluster; reset selects flat.
- R7: Shorthand 2'b01 (self) is accepted exactly when `msg_from_self` is 1.
- R8: Shorthand 2'b10 (all including self) is always accepted, whatever the destination.
- R9: Shorthand 2'b11 (all excluding self) is accepted exactly when `msg_from_self` is 0.
- R10: A register write applies to messages presented from the next cycle on; a write with `cfg_sel`=2'b11 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 00 physical id, 01 logical id, 10 format, 11 none |
| cfg_wdata | input | 32 | Register write data |
| msg_valid | input | 1 | A message is presented this cycle |
| msg_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| msg_dest | input | 8 | Message destination field |
| msg_short | input | 2 | Shorthand: 00 none, 01 self, 10 all including self, 11 all excluding self |
| msg_from_self | input | 1 | This controller is the message sender |
| acc_valid | output | 1 | A decision is reported this cycle |
| acc_hit | output | 1 | The reported message is accepted |

## Verification
Every decision is registered once, so `acc_valid` and `acc_hit` for a message driven before a rising edge are due right after that edge; the bench drives on the falling edge and reads the result on the next falling edge. A register write takes effect at the edge that samples it, so the bench sends the first message that depends on a new value in the cycle after the write and expects the new value to be in use. Two copies of the block with identical configuration are checked side by side for the shared-identifier case.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    typedef enum logic [1:0] {
        SH_NONE    = 2'b00,
        SH_SELF    = 2'b01,
        SH_ALL_INC = 2'b10,
        SH_ALL_EXC = 2'b11
    } short_e;

    typedef enum logic {
        FMT_FLAT    = 1'b0,
        FMT_CLUSTER = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        REG_PHYS  = 2'b00,
        REG_LOGIC = 2'b01,
        REG_FMT   = 2'b10,
        REG_NONE  = 2'b11
    } reg_sel_e;

endpackage

// File: rtl/ldm_cfg_regs.sv
module ldm_cfg_regs
    import ldm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W = 8,
    parameter int FMT_W = 4,
    parameter logic [ID_W-1:0] RESET_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [ID_W-1:0]   phys_id,
    output logic [ID_W-1:0]   log_id,
    output fmt_e              fmt
);
    localparam int ID_LO = DATA_W - ID_W;
    localparam int FMT_LO = DATA_W - FMT_W;

    logic [ID_W-1:0] wr_id;
    logic            wr_flat;
    logic            unused_low;

    assign wr_id = wdata[DATA_W-1:ID_LO];
    assign wr_flat = &wdata[DATA_W-1:FMT_LO];
    assign unused_low = ^wdata[ID_LO-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_id <= RESET_ID;
            log_id  <= '0;
            fmt     <= FMT_FLAT;
        end else if (we) begin
            unique case (sel)
                REG_PHYS:  phys_id <= wr_id;
                REG_LOGIC: log_id  <= wr_id;
                REG_FMT:   fmt     <= wr_flat ? FMT_FLAT : FMT_CLUSTER;
                REG_NONE:  ;
            endcase
        end
    end

    AST_NONE_SEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_NONE) |=> ($stable(phys_id) && $stable(log_id) && $stable(fmt))); // R10
    AST_PHYS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_PHYS) |=> (phys_id == $past(wdata[DATA_W-1:ID_LO]))); // R2

endmodule

// File: rtl/ldm_phys_match.sv
module ldm_phys_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] phys_id,
    input  logic [ID_W-1:0] dest,
    output logic            hit
);
    localparam logic [ID_W-1:0] BCAST = '1;

    logic exact;
    logic bcast;

    assign exact = (dest == phys_id);
    assign bcast = (dest == BCAST);
    assign hit = exact | bcast;

endmodule

// File: rtl/ldm_logic_match.sv
module ldm_logic_match
    import ldm_pkg::*;
#(
    parameter int ID_W = 8,
    parameter int CL_W = 4
) (
    input  logic [ID_W-1:0] log_id,
    input  fmt_e            fmt,
    input  logic [ID_W-1:0] dest,
    output logic            hit
);
    localparam int MEM_W = ID_W - CL_W;
    localparam logic [ID_W-1:0] BCAST = '1;

    logic flat_hit;
    logic clus_same;
    logic clus_overlap;
    logic clus_hit;

    assign flat_hit = |(dest & log_id);
    assign clus_same = (dest[ID_W-1:MEM_W] == log_id[ID_W-1:MEM_W]);
    assign clus_overlap = |(dest[MEM_W-1:0] & log_id[MEM_W-1:0]);
    assign clus_hit = (clus_same & clus_overlap) | (dest == BCAST);

    always_comb begin
        unique case (fmt)
            FMT_FLAT:    hit = flat_hit;
            FMT_CLUSTER: hit = clus_hit;
        endcase
    end

endmodule

// File: rtl/ldm_top.sv
module ldm_top
    import ldm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W = 8,
    parameter int CL_W = 4,
    parameter int FMT_W = 4,
    parameter logic [ID_W-1:0] RESET_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              msg_valid,
    input  logic              msg_logical,
    input  logic [ID_W-1:0]   msg_dest,
    input  logic [1:0]        msg_short,
    input  logic              msg_from_self,
    output logic              acc_valid,
    output logic              acc_hit
);
    logic [ID_W-1:0] phys_id;
    logic [ID_W-1:0] log_id;
    fmt_e            fmt;
    logic            phys_hit;
    logic            log_hit;
    logic            match;
    short_e          short_code;

    assign short_code = short_e'(msg_short);

    ldm_cfg_regs #(
        .DATA_W(DATA_W), .ID_W(ID_W), .FMT_W(FMT_W), .RESET_ID(RESET_ID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(reg_sel_e'(cfg_sel)),
        .wdata(cfg_wdata), .phys_id(phys_id), .log_id(log_id), .fmt(fmt)
    );

    ldm_phys_match #(.ID_W(ID_W)) u_phys (
        .phys_id(phys_id), .dest(msg_dest), .hit(phys_hit)
    );

    ldm_logic_match #(.ID_W(ID_W), .CL_W(CL_W)) u_logic (
        .log_id(log_id), .fmt(fmt), .dest(msg_dest), .hit(log_hit)
    );

    always_comb begin
        unique case (short_code)
            SH_NONE:    match = msg_logical ? log_hit : phys_hit;
            SH_SELF:    match = msg_from_self;
            SH_ALL_INC: match = 1'b1;
            SH_ALL_EXC: match = !msg_from_self;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_hit   <= 1'b0;
        end else begin
            acc_valid <= msg_valid;
            acc_hit   <= msg_valid & match;
        end
    end

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_hit); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> acc_valid); // R1
    AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_short == 2'b00 && !msg_logical && msg_dest == '1) |=> acc_hit); // R3
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_short == 2'b01) |=> (acc_hit == $past(msg_from_self))); // R7
    AST_ALL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_short == 2'b10) |=> acc_hit); // R8
    AST_ALL_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_short == 2'b11) |=> (acc_hit != $past(msg_from_self))); // R9

endmodule

// File: tb/ldm_top_bench.sv
module ldm_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    // entry: {logical, dest[7:0], short[1:0], from_self, expected}
    localparam logic [12:0] VECS [NVEC] = '{
        {1'b0, 8'h23, 2'b00, 1'b0, 1'b1},
        {1'b0, 8'h24, 2'b00, 1'b0, 1'b0},
        {1'b0, 8'hFF, 2'b00, 1'b0, 1'b1},
        {1'b1, 8'h02, 2'b00, 1'b0, 1'b1},
        {1'b1, 8'h10, 2'b00, 1'b0, 1'b1},
        {1'b1, 8'h21, 2'b00, 1'b0, 1'b0},
        {1'b1, 8'hED, 2'b00, 1'b0, 1'b0},
        {1'b0, 8'h00, 2'b01, 1'b1, 1'b1},
        {1'b0, 8'h23, 2'b01, 1'b0, 1'b0},
        {1'b0, 8'h00, 2'b10, 1'b0, 1'b1},
        {1'b1, 8'h00, 2'b10, 1'b1, 1'b1},
        {1'b0, 8'h23, 2'b11, 1'b1, 1'b0},
        {1'b0, 8'h00, 2'b11, 1'b0, 1'b1}
    };
    localparam string VTAG [NVEC] = '{
        "R2", "R2", "R3", "R4", "R4", "R4", "R4",
        "R7", "R7", "R8", "R8", "R9", "R9"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic [31:0] cfg_wdata = '0;
    logic        msg_valid = 1'b0;
    logic        msg_logical = 1'b0;
    logic [7:0]  msg_dest = '0;
    logic [1:0]  msg_short = 2'b00;
    logic        msg_from_self = 1'b0;
    logic        acc_valid, acc_hit, twin_valid, twin_hit;
    int          checks = 0;
    int          failures = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldm_top u_ldm_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_logical(msg_logical),
        .msg_dest(msg_dest), .msg_short(msg_short), .msg_from_self(msg_from_self),
        .acc_valid(acc_valid), .acc_hit(acc_hit)
    );

    ldm_top u_ldm_top_twin (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_logical(msg_logical),
        .msg_dest(msg_dest), .msg_short(msg_short), .msg_from_self(msg_from_self),
        .acc_valid(twin_valid), .acc_hit(twin_hit)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input string tag, input logic lg, input logic [7:0] d,
                        input logic [1:0] sh, input logic fs, input logic exp);
        @(negedge clk);
        msg_valid = 1'b1; msg_logical = lg; msg_dest = d;
        msg_short = sh; msg_from_self = fs;
        @(negedge clk);
        msg_valid = 1'b0;
        check(tag, acc_valid, 1'b1);
        check(tag, acc_hit, exp);
        check(tag, twin_hit, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", acc_valid, 1'b0);
        check("R1", acc_hit, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", acc_valid, 1'b0);
        check("R1", acc_hit, 1'b0);
        // R2/R4/R6 reset values: id 01, logical id 0, flat
        send("R2", 1'b0, 8'h01, 2'b00, 1'b0, 1'b1);
        send("R4", 1'b1, 8'hFF, 2'b00, 1'b0, 1'b0);

        write_reg(2'b00, 32'h23000000);
        write_reg(2'b01, 32'h12000000);
        for (int i = 0; i < NVEC; i++) begin
            send(VTAG[i], VECS[i][12], VECS[i][11:4], VECS[i][3:2], VECS[i][1], VECS[i][0]);
        end

        // R6/R5: switch to cluster, cluster 3 members 0101
        write_reg(2'b10, 32'h0FFFFFFF);
        write_reg(2'b01, 32'h35000000);
        send("R5", 1'b1, 8'h31, 2'b00, 1'b0, 1'b1);
        send("R5", 1'b1, 8'h32, 2'b00, 1'b0, 1'b0);
        send("R5", 1'b1, 8'h45, 2'b00, 1'b0, 1'b0);
        send("R5", 1'b1, 8'hFF, 2'b00, 1'b0, 1'b1);
        send("R5", 1'b1, 8'hF5, 2'b00, 1'b0, 1'b0);
        // R6: back to flat, 0x31 & 0x35 nonzero, 0x02 & 0x35 zero
        write_reg(2'b10, 32'hF0000000);
        send("R6", 1'b1, 8'h02, 2'b00, 1'b0, 1'b0);
        send("R6", 1'b1, 8'h04, 2'b00, 1'b0, 1'b1);

        // R10: select 11 writes nothing
        write_reg(2'b11, 32'h77000000);
        send("R10", 1'b0, 8'h23, 2'b00, 1'b0, 1'b1);
        send("R10", 1'b0, 8'h77, 2'b00, 1'b0, 1'b0);
        send("R10", 1'b1, 8'h04, 2'b00, 1'b0, 1'b1);
        // R10: new id in use in the cycle after the write
        write_reg(2'b00, 32'h40ABCDEF);
        send("R10", 1'b0, 8'h40, 2'b00, 1'b0, 1'b1);
        send("R2", 1'b0, 8'h23, 2'b00, 1'b0, 1'b0);

        // R1: idle cycle after a message
        @(negedge clk);
        check("R1", acc_valid, 1'b0);
        check("R1", acc_hit, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule